// File: doc/BRIEF.md
# Oversampled UART Receive Engine

This block recovers asynchronous serial characters from a receive line. A one-cycle tick, supplied by an external rate generator at sixteen times the baud rate, paces all sampling. The line is passed through a two-flop synchronizer. A high-to-low transition on the line starts a character, and the block confirms that start at the middle of the start bit. It then samples every following bit at its midpoint and assembles a byte of five to eight data bits, least significant first.

Configuration inputs set the character length, the parity mode and the number of stop bits. Each finished character is presented on a byte output with a valid strobe. The byte is held until a downstream holding buffer accepts it with a ready signal. Parity, framing, break and overrun conditions travel with the byte as flags.

Top module: `uart_rx_core`

## Requirements
- R1: After reset, out_valid and all status flags (out_parity_err, out_frame_err, out_break, out_overrun) are 0.
- R2: A character starts only on a high-to-low transition of the synchronized line. It is kept only if the line is still low at the middle of the start bit, 7 ticks after the transition tick. Otherwise the block returns to idle and delivers nothing.
- R3: cfg_len sets the number of data bits: code 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. Data bits arrive least significant first and land in out_data[0] upward. Bits at or above the character length read 0.
- R4: cfg_parity selects the parity mode: 0 none, 1 odd, 2 even, 3 forced 1, 4 forced 0. Codes 5 to 7 behave as none. When parity is enabled, one parity bit follows the data. out_parity_err is 1 when that bit differs from the value the mode demands. With no parity, out_parity_err is 0.
- R5: out_frame_err is 1 when the first stop bit samples low. When cfg_two_stop is 1, a second stop period follows and its value is not checked.
- R6: out_break is 1 when every data bit, the parity bit (if enabled) and the first stop bit all sample low. A break character is also reported with out_frame_err set and out_data equal to 0.
- R7: A delivered character raises out_valid. While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data stays unchanged. A cycle with both high accepts the character, and out_valid falls on the next edge.
- R8: If a character completes while the previous one is still held unaccepted, the new character is dropped. The held data is kept, and out_overrun rises until the held character is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | One-cycle strobe at sixteen times the baud rate |
| rxd | input | 1 | Serial receive line, idle high |
| cfg_len | input | 2 | Data bit count code (5 + code) |
| cfg_parity | input | 3 | Parity mode code |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| out_data | output | 8 | Received byte, zero-filled above the character length |
| out_valid | output | 1 | A character is held for acceptance |
| out_ready | input | 1 | Downstream accepts the held character |
| out_parity_err | output | 1 | Parity mismatch on the held character |
| out_frame_err | output | 1 | First stop bit was low |
| out_break | output | 1 | Whole character was low |
| out_overrun | output | 1 | A later character was dropped while this one was held |

## Verification
The assertions assume that the configuration inputs do not change while a character is being received or held. Under that assumption, the zero-fill check can read the current length code. The bench only changes the configuration after it has accepted the held character and while the line is idle. It drives rxd in whole sixteen-tick bit periods aligned to tick16. Each frame is followed by an idle-high gap, so every start arrives as a clean falling edge.

// File: rtl/uart_rx_core.sv
module uart_rx_core #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       rxd,
  input  logic [1:0] cfg_len,
  input  logic [2:0] cfg_parity,
  input  logic       cfg_two_stop,
  output logic [7:0] out_data,
  output logic       out_valid,
  input  logic       out_ready,
  output logic       out_parity_err,
  output logic       out_frame_err,
  output logic       out_break,
  output logic       out_overrun
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP1, S_STOP2} st_t;

  st_t          st;
  logic [1:0]   sync;
  logic         rx_prev;
  logic [CW-1:0] cnt;
  logic [2:0]   bitn;
  logic [7:0]   sh;
  logic         par_acc, any_hi, perr_r, ferr_r, brk_r;

  wire rx_s     = sync[1];
  wire at_last  = tick16 && (cnt == LAST);
  wire par_en   = (cfg_parity >= 3'd1) && (cfg_parity <= 3'd4);
  wire last_bit = (bitn == 3'(cfg_len + 2'd0) + 3'd4);

  logic par_want;
  always_comb begin
    case (cfg_parity)
      3'd1:    par_want = ~par_acc;
      3'd2:    par_want = par_acc;
      3'd3:    par_want = 1'b1;
      default: par_want = 1'b0;
    endcase
  end

  wire done    = at_last && ((st == S_STOP1 && !cfg_two_stop) || st == S_STOP2);
  wire fin_fe  = (st == S_STOP1) ? ~rx_s : ferr_r;
  wire fin_brk = (st == S_STOP1) ? (~rx_s & ~any_hi) : brk_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync <= 2'b11;
    end else begin
      sync <= {sync[0], rxd};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; rx_prev <= 1'b1; cnt <= '0; bitn <= '0; sh <= '0;
      par_acc <= 1'b0; any_hi <= 1'b0; perr_r <= 1'b0; ferr_r <= 1'b0; brk_r <= 1'b0;
    end else if (tick16) begin
      rx_prev <= rx_s;
      cnt <= cnt + 1'b1;
      case (st)
        S_IDLE: begin
          cnt <= CW'(1);
          if (rx_prev && !rx_s) st <= S_START;
        end
        S_START: if (cnt == MID) begin
          if (!rx_s) begin
            st <= S_DATA; cnt <= '0; bitn <= '0; sh <= '0;
            par_acc <= 1'b0; any_hi <= 1'b0; perr_r <= 1'b0;
          end else begin
            st <= S_IDLE;
          end
        end
        S_DATA: if (cnt == LAST) begin
          sh[bitn] <= rx_s;
          par_acc  <= par_acc ^ rx_s;
          any_hi   <= any_hi | rx_s;
          bitn     <= bitn + 1'b1;
          if (last_bit) st <= par_en ? S_PAR : S_STOP1;
        end
        S_PAR: if (cnt == LAST) begin
          perr_r <= (rx_s != par_want);
          any_hi <= any_hi | rx_s;
          st     <= S_STOP1;
        end
        S_STOP1: if (cnt == LAST) begin
          ferr_r <= ~rx_s;
          brk_r  <= ~rx_s & ~any_hi;
          st     <= cfg_two_stop ? S_STOP2 : S_IDLE;
        end
        S_STOP2: if (cnt == LAST) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data <= '0; out_valid <= 1'b0; out_parity_err <= 1'b0;
      out_frame_err <= 1'b0; out_break <= 1'b0; out_overrun <= 1'b0;
    end else if (done) begin
      if (out_valid && !out_ready) begin
        out_overrun <= 1'b1;
      end else begin
        out_data <= sh; out_valid <= 1'b1; out_parity_err <= perr_r;
        out_frame_err <= fin_fe; out_break <= fin_brk; out_overrun <= 1'b0;
      end
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
      out_overrun <= 1'b0;
    end
  end

  assert_start_path_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DATA && $past(st) != S_DATA) |-> $past(st) == S_START);
  assert_zero_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_data >> (4'(cfg_len) + 4'd5)) == 8'd0));
  assert_break_shape_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_break) |-> (out_frame_err && out_data == 8'd0));
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  assert_overrun_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_overrun |-> out_valid);
endmodule

// File: tb/test_uart_rx_core.sv
`timescale 1ns/1ps
module test_uart_rx_core;
  logic clk = 1'b0, rst_n = 1'b0, tick16 = 1'b0, rxd = 1'b1, out_ready = 1'b0;
  logic [1:0] cfg_len = 2'd3;
  logic [2:0] cfg_parity = 3'd0;
  logic cfg_two_stop = 1'b0;
  logic [7:0] out_data;
  logic out_valid, out_parity_err, out_frame_err, out_break, out_overrun;
  int checks = 0, failures = 0;
  bit done = 0;
  logic [1:0] tdiv = '0;

  always #2.5 clk = ~clk;
  always_ff @(posedge clk) begin
    tdiv <= tdiv + 1'b1;
    tick16 <= (tdiv == 2'd3);
  end

  uart_rx_core i_uart_rx_core (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) begin
      @(negedge clk);
      while (!tick16) @(negedge clk);
    end
  endtask

  function automatic logic par_of(input logic [7:0] d, input int nb, input logic [2:0] pm);
    logic p = ^(d & 8'((1 << nb) - 1));
    case (pm)
      3'd1: return ~p;
      3'd2: return p;
      3'd3: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic send(input logic [7:0] d, input logic pbit, input logic s1, input logic s2);
    int nb = int'(cfg_len) + 5;
    rxd = 1'b0; wt(16);
    for (int i = 0; i < nb; i++) begin rxd = d[i]; wt(16); end
    if (cfg_parity >= 3'd1 && cfg_parity <= 3'd4) begin rxd = pbit; wt(16); end
    rxd = s1; wt(16);
    if (cfg_two_stop) begin rxd = s2; wt(16); end
    rxd = 1'b1; wt(24);
  endtask

  task automatic accept;
    @(negedge clk); out_ready = 1'b1;
    @(negedge clk); out_ready = 1'b0;
    chk("R7 valid falls after accept", out_valid, 0);
  endtask

  task automatic frame(input string tag, input logic [7:0] d, input bit bad_par, input logic s1, input logic s2);
    int nb = int'(cfg_len) + 5;
    logic [7:0] dm = d & 8'((1 << nb) - 1);
    bit pe = (cfg_parity >= 3'd1 && cfg_parity <= 3'd4);
    logic pb = par_of(dm, nb, cfg_parity) ^ bad_par;
    send(d, pb, s1, s2);
    chk({tag, " R7 valid"}, out_valid, 1);
    chk({tag, " R3 data"}, out_data, dm);
    chk({tag, " R4 parity"}, out_parity_err, pe && bad_par);
    chk({tag, " R5 framing"}, out_frame_err, !s1);
    chk({tag, " R6 break"}, out_break, (dm == 0) && !s1 && (!pe || !pb));
    chk({tag, " R8 no overrun"}, out_overrun, 0);
    accept();
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    chk("R1 valid", out_valid, 0);
    chk("R1 flags", {out_parity_err, out_frame_err, out_break, out_overrun}, 0);
    rst_n = 1'b1;
    wt(20);
    frame("8N1", 8'hA5, 0, 1, 1);
    cfg_len = 2'd0; frame("5N1 zero fill", 8'hFF, 0, 1, 1);
    cfg_len = 2'd2; cfg_parity = 3'd1; frame("7O1", 8'h35, 0, 1, 1);
    frame("7O1 bad", 8'h35, 1, 1, 1);
    cfg_parity = 3'd2; frame("7E1 bad", 8'h0F, 1, 1, 1);
    cfg_parity = 3'd3; frame("mark", 8'h12, 0, 1, 1);
    cfg_parity = 3'd4; frame("space bad", 8'h12, 1, 1, 1);
    cfg_parity = 3'd0; cfg_two_stop = 1'b1; frame("R5 second stop ignored", 8'h5A, 0, 1, 0);
    cfg_two_stop = 1'b0; frame("R5 stop low", 8'h5A, 0, 0, 1);
    cfg_len = 2'd3; cfg_parity = 3'd2; frame("R6 break", 8'h00, 0, 0, 1);
    rxd = 1'b0; wt(3); rxd = 1'b1; wt(40);
    chk("R2 short glitch rejected", out_valid, 0);
    cfg_parity = 3'd0;
    send(8'h3C, 0, 1, 1);
    send(8'hC3, 0, 1, 1);
    chk("R8 held valid", out_valid, 1);
    chk("R8 held data kept", out_data, 8'h3C);
    chk("R8 overrun flagged", out_overrun, 1);
    accept();
    chk("R8 overrun cleared", out_overrun, 0);
    for (int k = 0; k < 40; k++) begin
      cfg_len = 2'($urandom_range(0, 3));
      cfg_parity = 3'($urandom_range(0, 4));
      cfg_two_stop = 1'($urandom_range(0, 1));
      frame("rand", 8'($urandom), ($urandom_range(0, 3) == 0), ($urandom_range(0, 4) != 0), 1'b1);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule